// File: doc/BRIEF.md
# Packed Sub-Word Minimum/Maximum Unit

This block carries out one packed min/max operation each cycle. An instruction word of 64 bits and three 32-bit data words (A, B and C) enter together under an input strobe. The block picks a lane of A and a lane of B. Each lane is a byte, a halfword or the full word, and each is signed or unsigned. B may instead come from a 20-bit immediate held in the instruction.

The block compares the two extended values exactly, including when one operand is signed and the other is not. It can then clamp the winner to the signedness the destination wants. A final stage combines the result with C. That stage can insert the result into part of C, add C to it, take the min or max against C, or pass the result through.

The result is held in a register and appears one clock after the input strobe, marked by an output strobe. Register-file access, flag generation and fetch are done elsewhere.

Top module: `subword_minmax_alu`

## Requirements
- R1: The width of A comes from instruction bits 38:37: code 2 gives a halfword, code 3 the full word, and codes 0 and 1 a byte. The lane select for A is bits 37:36. A byte lane k is bits 8k+7:8k. For a halfword only bit 36 counts, and it picks bits 31:16 when set. For a full word the select is ignored.
- R2: Bit 48 set makes the A lane sign-extended to the full width, and bit 48 clear makes it zero-extended.
- R3: When bit 50 is set, B is taken from the B data word. Its width comes from bits 30:29 and its lane select from bits 29:28, with the same codes and lane rules as R1. Bit 49 then chooses sign extension (set) or zero extension (clear).
- R4: When bit 50 is clear, B is the 20-bit immediate in bits 35:16. It is sign-extended from bit 19 when bit 49 is set and zero-extended otherwise, and the B data word is ignored.
- R5: Bit 56 set selects the larger operand and clear the smaller one. When both operands have the same signedness, the comparison uses that signedness and the result carries it.
- R6: When the operands differ in signedness, the numerically correct operand is chosen. A maximum is then treated as unsigned and a minimum as signed.
- R7: With bit 55 set, an unsigned result is clamped to at most 0x7FFFFFFF when bit 54 is set. With bit 55 set, a signed result is clamped to at least 0 when bit 54 is clear. In every other case the result is unchanged.
- R8: The post-stage code sits in bits 53:51, and codes 0 to 3 insert the result into C:
  - code 0 writes result[15:0] to bits 31:16;
  - code 1 writes result[15:0] to bits 15:0;
  - code 2 writes result[7:0] to bits 7:0;
  - code 3 writes result[7:0] to bits 23:16.
- R9: Post-stage code 4 returns the result plus C, wrapping modulo 2^32.
- R10: Post-stage code 5 returns the smaller and code 6 the larger of the result and C, compared as signed when bit 54 is set and as unsigned otherwise. Code 7 returns the result unchanged.
- R11: out_valid follows in_valid one clock later, and result is loaded only when in_valid is high. A synchronous active-high reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| instr | input | 64 | Instruction word |
| opa | input | 32 | Data word A |
| opb | input | 32 | Data word B (unused for immediate B) |
| opc | input | 32 | Data word C for the post-stage |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 32 | Registered final result |

## Verification
The bench pairs an unsigned 0x80000000 with a signed -5 under both max and min. A design that compared both as unsigned would return -5 for the max. A design that compared both as signed would return 0x80000000 for the min.

Saturation is applied to those same mixed results. A wrong clamp direction would leave 0x80000000 or 0xFFFFFFFB in place of 0x7FFFFFFF or 0.

Lane tests use distinct byte values in every position, so a wrong shift or a missed sign extension shows up as a different value. The insert codes use a C word whose bytes are all different, which exposes a result written to the wrong field. A signed immediate of all ones would turn into 0xFFFFF if its sign were dropped.

// File: rtl/swmm_pkg.sv
package swmm_pkg;

  localparam int IMM_W = 20;

  // instruction field positions (the operation is defined by them)
  localparam int A_SEL_LO  = 36;
  localparam int A_WID_LO  = 37;
  localparam int B_SEL_LO  = 28;
  localparam int B_WID_LO  = 29;
  localparam int IMM_LO    = 16;
  localparam int A_SGN_BIT = 48;
  localparam int B_SGN_BIT = 49;
  localparam int B_REG_BIT = 50;
  localparam int POST_LO   = 51;
  localparam int DSGN_BIT  = 54;
  localparam int SAT_BIT   = 55;
  localparam int MAX_BIT   = 56;

  typedef enum logic [1:0] {
    LW_BYTE = 2'd0,
    LW_HALF = 2'd1,
    LW_WORD = 2'd2
  } lane_w_e;

  typedef enum logic [2:0] {
    PO_HI16 = 3'd0,
    PO_LO16 = 3'd1,
    PO_B0   = 3'd2,
    PO_B2   = 3'd3,
    PO_ADD  = 3'd4,
    PO_MIN  = 3'd5,
    PO_MAX  = 3'd6,
    PO_PASS = 3'd7
  } post_e;

  typedef struct packed {
    lane_w_e              a_w;
    logic [1:0]           a_sel;
    logic                 a_sgn;
    lane_w_e              b_w;
    logic [1:0]           b_sel;
    logic                 b_sgn;
    logic                 b_reg;
    logic [IMM_W-1:0]     imm;
    logic                 is_max;
    logic                 sat;
    logic                 dst_sgn;
    post_e                post;
  } op_dec_t;

  function automatic lane_w_e width_code(logic [1:0] code);
    case (code)
      2'd2:    return LW_HALF;
      2'd3:    return LW_WORD;
      default: return LW_BYTE;
    endcase
  endfunction

  function automatic logic [1:0] trim_sel(lane_w_e w, logic [1:0] raw);
    case (w)
      LW_HALF: return {1'b0, raw[0]};
      LW_WORD: return 2'd0;
      default: return raw;
    endcase
  endfunction

  function automatic op_dec_t decode_op(logic [63:0] iw);
    op_dec_t d;
    d.a_w     = width_code(iw[A_WID_LO +: 2]);
    d.a_sel   = trim_sel(d.a_w, iw[A_SEL_LO +: 2]);
    d.a_sgn   = iw[A_SGN_BIT];
    d.b_w     = width_code(iw[B_WID_LO +: 2]);
    d.b_sel   = trim_sel(d.b_w, iw[B_SEL_LO +: 2]);
    d.b_sgn   = iw[B_SGN_BIT];
    d.b_reg   = iw[B_REG_BIT];
    d.imm     = iw[IMM_LO +: IMM_W];
    d.is_max  = iw[MAX_BIT];
    d.sat     = iw[SAT_BIT];
    d.dst_sgn = iw[DSGN_BIT];
    d.post    = post_e'(iw[POST_LO +: 3]);
    return d;
  endfunction

endpackage

// File: rtl/swmm_operand_unit.sv
module swmm_operand_unit
  import swmm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     word,
  input  lane_w_e          lw,
  input  logic [1:0]       sel,
  input  logic             sgn,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  output logic [W:0]       ext
);

  localparam int BY = 8;
  localparam int HW = 16;

  function automatic logic [W:0] lane_extend(logic [W-1:0] w, lane_w_e l,
                                             logic [1:0] s, logic sg);
    logic [W-1:0] sh;
    logic [W:0]   r;
    sh = w;
    case (l)
      LW_BYTE: begin
        sh = w >> {s, 3'b000};
        r  = {{(W+1-BY){sg & sh[BY-1]}}, sh[BY-1:0]};
      end
      LW_HALF: begin
        sh = w >> {s[0], 4'b0000};
        r  = {{(W+1-HW){sg & sh[HW-1]}}, sh[HW-1:0]};
      end
      default: r = {sg & w[W-1], w};
    endcase
    return r;
  endfunction

  function automatic logic [W:0] imm_extend(logic [IMM_W-1:0] v, logic sg);
    return {{(W+1-IMM_W){sg & v[IMM_W-1]}}, v};
  endfunction

  logic [W:0] lane_val;
  logic [W:0] imm_val;

  always_comb begin
    lane_val = lane_extend(word, lw, sel, sgn);
    imm_val  = imm_extend(imm, sgn);
    ext      = use_imm ? imm_val : lane_val;
  end

endmodule

// File: rtl/swmm_select_unit.sv
module swmm_select_unit #(
  parameter int W = 32
) (
  input  logic [W:0]   a_ext,
  input  logic [W:0]   b_ext,
  input  logic         a_sgn,
  input  logic         b_sgn,
  input  logic         is_max,
  output logic [W:0]   pick,
  output logic         res_sgn
);

  // both inputs are exact W+1 bit two's complement values
  function automatic logic a_greater(logic [W:0] a, logic [W:0] b);
    return $signed(a) > $signed(b);
  endfunction

  logic gt;

  always_comb begin
    gt      = a_greater(a_ext, b_ext);
    pick    = (is_max == gt) ? a_ext : b_ext;
    res_sgn = (a_sgn == b_sgn) ? a_sgn : !is_max;
  end

endmodule

// File: rtl/swmm_post_unit.sv
module swmm_post_unit
  import swmm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         res_sgn,
  input  logic         sat_en,
  input  logic         dst_sgn,
  input  post_e        post,
  input  logic [W-1:0] c,
  output logic [W-1:0] sat_v,
  output logic [W-1:0] out
);

  localparam int H  = W / 2;
  localparam int BY = 8;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  function automatic logic less_than(logic [W-1:0] x, logic [W-1:0] y, logic sg);
    return sg ? ($signed(x) < $signed(y)) : (x < y);
  endfunction

  logic c_lt;

  always_comb begin
    sat_v = res;
    if (sat_en && res[W-1]) begin
      if (dst_sgn && !res_sgn)      sat_v = SMAX;
      else if (!dst_sgn && res_sgn) sat_v = '0;
    end
    c_lt = less_than(sat_v, c, dst_sgn);
    case (post)
      PO_HI16: out = {sat_v[H-1:0], c[H-1:0]};
      PO_LO16: out = {c[W-1:H], sat_v[H-1:0]};
      PO_B0:   out = {c[W-1:BY], sat_v[BY-1:0]};
      PO_B2:   out = {c[W-1:H+BY], sat_v[BY-1:0], c[H-1:0]};
      PO_ADD:  out = sat_v + c;
      PO_MIN:  out = c_lt ? sat_v : c;
      PO_MAX:  out = c_lt ? c : sat_v;
      default: out = sat_v;
    endcase
  end

endmodule

// File: rtl/subword_minmax_alu.sv
module subword_minmax_alu
  import swmm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic [DATA_W-1:0]  opc,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result
);

  op_dec_t           d;
  logic [DATA_W:0]   a_ext;
  logic [DATA_W:0]   b_ext;
  logic [DATA_W:0]   pick;
  logic              res_sgn;
  logic [DATA_W-1:0] sat_v;
  logic [DATA_W-1:0] post_v;

  always_comb d = decode_op(instr[63:0]);

  swmm_operand_unit #(.W(DATA_W)) u_opa (
    .word(opa), .lw(d.a_w), .sel(d.a_sel), .sgn(d.a_sgn),
    .use_imm(1'b0), .imm('0), .ext(a_ext)
  );

  swmm_operand_unit #(.W(DATA_W)) u_opb (
    .word(opb), .lw(d.b_w), .sel(d.b_sel), .sgn(d.b_sgn),
    .use_imm(!d.b_reg), .imm(d.imm), .ext(b_ext)
  );

  swmm_select_unit #(.W(DATA_W)) u_sel (
    .a_ext(a_ext), .b_ext(b_ext), .a_sgn(d.a_sgn), .b_sgn(d.b_sgn),
    .is_max(d.is_max), .pick(pick), .res_sgn(res_sgn)
  );

  swmm_post_unit #(.W(DATA_W)) u_post (
    .res(pick[DATA_W-1:0]), .res_sgn(res_sgn), .sat_en(d.sat),
    .dst_sgn(d.dst_sgn), .post(d.post), .c(opc),
    .sat_v(sat_v), .out(post_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= post_v;
    end
  end

  // R5: the chosen operand bounds both inputs
  a_r5_max_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && d.is_max) |->
      ($signed(pick) >= $signed(a_ext) && $signed(pick) >= $signed(b_ext)));

  a_r5_min_lower: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !d.is_max) |->
      ($signed(pick) <= $signed(a_ext) && $signed(pick) <= $signed(b_ext)));

  // R6: the winner is one of the inputs and fits the result signedness
  a_r6_pick_member: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (pick == a_ext || pick == b_ext));

  a_r6_fits_width: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (res_sgn ? (pick[DATA_W] == pick[DATA_W-1]) : !pick[DATA_W]));

  // R7: a clamp across signedness never leaves the top bit set
  a_r7_sat_nonneg: assert property (@(posedge clk) disable iff (rst)
    (in_valid && d.sat && (d.dst_sgn != res_sgn)) |-> !sat_v[DATA_W-1]);

  // R11: strobe timing and result hold
  a_r11_valid_next: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

endmodule

// File: tb/sim_subword_minmax_alu.sv
`timescale 1ns/1ps
module sim_subword_minmax_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] instr = '0;
  logic [31:0] opa = '0, opb = '0, opc = '0;
  logic        out_valid;
  logic [31:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_exp;
  bit          have_last = 0;

  always #4 clk = ~clk;

  subword_minmax_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .opa(opa), .opb(opb), .opc(opc), .out_valid(out_valid), .result(result)
  );

  // af/bf: raw 3-bit field {width code, low select}; a byte lane k is af = {1'b0, k}
  function automatic logic [63:0] mk(logic [2:0] af, bit asg, logic [2:0] bf, bit bsg,
                                     bit breg, logic [19:0] imm, bit ismax,
                                     bit sat, bit dsg, logic [2:0] post);
    logic [63:0] w = '0;
    w[38:36] = af;
    w[48]    = asg;
    w[49]    = bsg;
    w[50]    = breg;
    if (breg) w[30:28] = bf;
    else      w[35:16] = imm;
    w[53:51] = post;
    w[54]    = dsg;
    w[55]    = sat;
    w[56]    = ismax;
    return w;
  endfunction

  function automatic longint lane(logic [31:0] w, logic [1:0] code, logic [1:0] rawsel, bit sg);
    int     nb;
    int     s;
    longint v;
    longint span;
    nb = (code == 2) ? 16 : (code == 3) ? 32 : 8;
    s  = (nb == 8) ? int'(rawsel) : (nb == 16) ? int'(rawsel[0]) : 0;
    span = longint'(1) << nb;
    v = (longint'(w) >> (s * nb)) & (span - 1);
    if (sg && ((v >> (nb - 1)) & 1) == 1) v = v - span;
    return v;
  endfunction

  function automatic logic [31:0] model(logic [63:0] iw, logic [31:0] a, logic [31:0] b,
                                        logic [31:0] c);
    longint va, vb, r;
    bit sa, sb, rs, mx;
    logic [31:0] x;
    logic [32:0] xs, cs;
    sa = iw[48];
    sb = iw[49];
    va = lane(a, iw[38:37], iw[37:36], sa);
    if (iw[50]) vb = lane(b, iw[30:29], iw[29:28], sb);
    else begin
      vb = longint'(iw[35:16]);
      if (sb && iw[35]) vb = vb - (longint'(1) << 20);
    end
    mx = iw[56];
    if (mx) r = (va > vb) ? va : vb;
    else    r = (va < vb) ? va : vb;
    rs = (sa == sb) ? sa : !mx;
    x  = r[31:0];
    if (iw[55]) begin
      if (iw[54] && !rs && r > 64'sh7FFFFFFF) x = 32'h7FFFFFFF;
      if (!iw[54] && rs && r < 0)             x = 32'h0;
    end
    xs = iw[54] ? {x[31], x} : {1'b0, x};
    cs = iw[54] ? {c[31], c} : {1'b0, c};
    case (iw[53:51])
      3'd0: return {x[15:0], c[15:0]};
      3'd1: return {c[31:16], x[15:0]};
      3'd2: return {c[31:8], x[7:0]};
      3'd3: return {c[31:24], x[7:0], c[15:0]};
      3'd4: return x + c;
      3'd5: return ($signed(xs) < $signed(cs)) ? x : c;
      3'd6: return ($signed(xs) > $signed(cs)) ? x : c;
      default: return x;
    endcase
  endfunction

  task automatic issue(string tag, logic [63:0] iw, logic [31:0] a, logic [31:0] b,
                       logic [31:0] c, logic [31:0] hand);
    logic [31:0] m;
    m = model(iw, a, b, c);
    n_tests++;
    if (m !== hand) begin
      n_fail++;
      $display("FAIL %s model got %h expected %h", tag, m, hand);
    end
    @(negedge clk);
    instr = iw; opa = a; opb = b; opc = c; in_valid = 1'b1;
    exp_q.push_back(hand);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opb = 32'hDEAD_BEEF;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R11 out_valid with nothing pending: got 1 expected 0");
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (result !== e) begin
            n_fail++;
            $display("FAIL %s result got %h expected %h", t, result, e);
          end
          last_exp  = e;
          have_last = 1;
        end
      end else if (have_last) begin
        n_tests++;
        if (result !== last_exp) begin
          n_fail++;
          $display("FAIL R11 held result got %h expected %h", result, last_exp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset out_valid got %b expected 0", out_valid);
    end
    rst = 1'b0;
    @(negedge clk);

    // R1: byte lane 2 of A, unsigned max against unsigned word B
    issue("R1", mk(3'b010, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd7), 32'h44AA2211, 32'h50, 0, 32'h000000AA);
    // R2: same lane signed, min
    issue("R2", mk(3'b010, 1, 3'b110, 1, 1, 0, 0, 0, 0, 3'd7), 32'h44AA2211, 32'h50, 0, 32'hFFFFFFAA);
    // R1: upper halfword, unsigned
    issue("R1", mk(3'b101, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd7), 32'h80011234, 32'h5, 0, 32'h00008001);
    // R2: upper halfword signed, min
    issue("R2", mk(3'b101, 1, 3'b110, 1, 1, 0, 0, 0, 0, 3'd7), 32'h80011234, 32'h5, 0, 32'hFFFF8001);
    // R3: B byte lane 3 signed
    issue("R3", mk(3'b110, 1, 3'b011, 1, 1, 0, 0, 0, 0, 3'd7), 32'h10, 32'h80000000, 0, 32'hFFFFFF80);
    // R3: B lower halfword unsigned, max
    issue("R3", mk(3'b110, 0, 3'b100, 0, 1, 0, 1, 0, 0, 3'd7), 32'h10, 32'h1234FFFE, 0, 32'h0000FFFE);
    // R4: signed immediate all ones
    issue("R4", mk(3'b110, 1, 3'b000, 1, 0, 20'hFFFFF, 1, 0, 0, 3'd7), 32'hFFFFFFF0, 32'h7FFF_FFFF, 0, 32'hFFFFFFFF);
    // R4: unsigned immediate with top bit set
    issue("R4", mk(3'b110, 0, 3'b000, 0, 0, 20'h80000, 1, 0, 0, 3'd7), 32'h7, 32'hFFFF_FFFF, 0, 32'h00080000);
    // R5: unsigned min
    issue("R5", mk(3'b110, 0, 3'b110, 0, 1, 0, 0, 0, 0, 3'd7), 32'h3, 32'h9, 0, 32'h3);
    // R6: mixed signedness max/min
    issue("R6", mk(3'b110, 0, 3'b110, 1, 1, 0, 1, 0, 0, 3'd7), 32'h80000000, 32'hFFFFFFFB, 0, 32'h80000000);
    issue("R6", mk(3'b110, 0, 3'b110, 1, 1, 0, 0, 0, 0, 3'd7), 32'h80000000, 32'hFFFFFFFB, 0, 32'hFFFFFFFB);
    // R7: saturation both directions, and no clamp when signedness agrees
    issue("R7", mk(3'b110, 0, 3'b110, 1, 1, 0, 1, 1, 1, 3'd7), 32'h80000000, 32'hFFFFFFFB, 0, 32'h7FFFFFFF);
    issue("R7", mk(3'b110, 0, 3'b110, 1, 1, 0, 0, 1, 0, 3'd7), 32'h80000000, 32'hFFFFFFFB, 0, 32'h00000000);
    issue("R7", mk(3'b110, 1, 3'b110, 1, 1, 0, 0, 1, 1, 3'd7), 32'h80000000, 32'hFFFFFFFB, 0, 32'h80000000);
    idle(2);
    // R8: insert codes
    issue("R8", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd0), 32'hA1B2, 32'h0, 32'h11223344, 32'hA1B23344);
    issue("R8", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd1), 32'hA1B2, 32'h0, 32'h11223344, 32'h1122A1B2);
    issue("R8", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd2), 32'hA1B2, 32'h0, 32'h11223344, 32'h112233B2);
    issue("R8", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd3), 32'hA1B2, 32'h0, 32'h11223344, 32'h11B23344);
    // R9: wrap-around add
    issue("R9", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd4), 32'hFFFFFFF0, 32'h0, 32'h20, 32'h00000010);
    // R10: min/max against C with destination signedness, and pass
    issue("R10", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 1, 3'd5), 32'hFFFFFFF0, 32'h0, 32'h5, 32'hFFFFFFF0);
    issue("R10", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd5), 32'hFFFFFFF0, 32'h0, 32'h5, 32'h00000005);
    issue("R10", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 1, 3'd6), 32'hFFFFFFF0, 32'h0, 32'h5, 32'h00000005);
    issue("R10", mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd6), 32'hFFFFFFF0, 32'h0, 32'h5, 32'hFFFFFFF0);
    idle(4);

    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11 pending results got %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule